// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or discarded. The decision rests on the frame's 48-bit destination address and a small set of receive-control inputs. A one-cycle start strobe presents the address. One clock later the block returns a registered accept/drop result, qualified by a one-cycle valid pulse.

The decision uses two programmable tables. The first is a 16-entry exact-match table. Each entry is a low and a high 32-bit word and carries its own valid flag. The second is a 4096-bit inexact hash table, organised as 128 words of 32 bits. Both tables are loaded through a plain word-addressed write port.

Four ways of passing are tried in a fixed priority order:
- accept everything;
- accept group addresses;
- accept broadcast;
- exact match, then hash lookup.

The first way that passes accepts the frame.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset both tables are empty (every exact entry invalid, every hash bit zero) and `dec_valid_o` is low, so with all control inputs low every frame is dropped.
- R2: When `ucast_promisc_i` is high, every frame is accepted whatever its destination.
- R3: When `mcast_promisc_i` is high, a destination whose byte 0 (`dst_addr_i[7:0]`) has bit 0 set is accepted; a destination with that bit clear is not accepted by this rule.
- R4: When `bcast_en_i` is high, a destination of all ones is accepted; with `bcast_en_i` low, an all-ones destination gets no special treatment.
- R5: Exact entry k sits at word address 2k (low word) and 2k+1 (high word). The low word holds address bytes 0..3 (byte 0 in bits [7:0]). The high word holds byte 4 in [7:0], byte 5 in [15:8] and the valid flag in bit 31. Only a valid entry whose 48 address bits equal the destination accepts the frame.
- R6: The hash index is the 16-bit key {byte 5, byte 4} (`dst_addr_i[47:32]`) shifted right by 4, 3, 2 or 0 places for `mc_offset_i` = 0, 1, 2 or 3, then cut to its low 12 bits.
- R7: Hash word w sits at word address 128+w. Index bits [11:5] select the word and bits [4:0] select the bit. The frame is accepted if that bit is one and no earlier check passed, and dropped otherwise.
- R8: `dec_valid_o` pulses for exactly the one cycle after `chk_start_i`. `accept_o` is updated only then and holds its value until the next start.
- R9: Writes to word addresses 32 to 127 change neither table, so they have no effect on any decision.
- R10: The checks are ordered unicast promiscuous, multicast promiscuous, broadcast, exact match, hash. At most one of them is the deciding check, and the frame is accepted when any check passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | 8 | Table word address |
| wr_data_i | input | 32 | Table write data |
| ucast_promisc_i | input | 1 | Accept every frame |
| mcast_promisc_i | input | 1 | Accept every group-address frame |
| bcast_en_i | input | 1 | Accept the all-ones destination |
| mc_offset_i | input | 2 | Hash key shift select |
| chk_start_i | input | 1 | Start strobe for a decision |
| dst_addr_i | input | 48 | Destination address, byte 0 in [7:0] |
| dec_valid_o | output | 1 | Decision valid pulse |
| accept_o | output | 1 | 1 = accept, 0 = drop |

## Verification
The assertions assume that the control inputs and `dst_addr_i` are steady in the cycle that `chk_start_i` is high. They also assume that no table write in that same cycle targets the entry or word being looked up, because the lookup sees the table contents from before the write.

The bench drives every input on the falling edge and raises the start strobe only after the last write has settled. It keeps writes and lookups in separate cycles.

The hash index space is swept exhaustively with a single bit set. The exact table is checked against every single-bit change of a stored address.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned MAC_W    = 48;
  localparam int unsigned KEY_W    = 16;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BITSEL_W = 5;
  localparam int unsigned CHK_N    = 5;
  // check positions, lowest index wins
  localparam int unsigned CHK_UPE   = 0;
  localparam int unsigned CHK_MPE   = 1;
  localparam int unsigned CHK_BCAST = 2;
  localparam int unsigned CHK_EXACT = 3;
  localparam int unsigned CHK_HASH  = 4;

  function automatic logic [3:0] mo_shift(input logic [1:0] mo);
    case (mo)
      2'd0:    return 4'd4;
      2'd1:    return 4'd3;
      2'd2:    return 4'd2;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/rxf_exact_table.sv
module rxf_exact_table
  import rxf_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [MAC_W-1:0]  dst_i,
  output logic              hit_o
);
  localparam int unsigned EW = $clog2(N_ENT);

  logic             in_region;
  logic [N_ENT-1:0] match_v;

  assign in_region = we_i && (waddr_i[AW-1:EW+1] == '0);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [WORD_W-1:0] lo_q, hi_q;
    logic              sel;
    assign sel = in_region && (waddr_i[EW:1] == EW'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (sel) begin
        if (waddr_i[0]) hi_q <= wdata_i;
        else            lo_q <= wdata_i;
      end
    end

    assign match_v[e] = hi_q[WORD_W-1] && (lo_q == dst_i[31:0]) &&
                        (hi_q[15:0] == dst_i[47:32]);
  end

  assign hit_o = |match_v;
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
  import rxf_pkg::*;
#(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned AW    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [1:0]        mo_i,
  output logic              hit_o
);
  localparam int unsigned WIDX_W = IDX_W - BITSEL_W;
  localparam int unsigned WORDS  = 1 << WIDX_W;
  localparam int unsigned RGN_W  = AW - WIDX_W;
  localparam logic [RGN_W-1:0] REGION = RGN_W'(1);

  logic [WORD_W-1:0] mem_q [WORDS];
  logic [KEY_W-1:0]  shifted;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] sel_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < int'(WORDS); w++) mem_q[w] <= '0;
    end else if (we_i && (waddr_i[AW-1:WIDX_W] == REGION)) begin
      mem_q[waddr_i[WIDX_W-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    shifted  = key_i >> mo_shift(mo_i);
    idx      = shifted[IDX_W-1:0];
    sel_word = mem_q[idx[IDX_W-1:BITSEL_W]];
    hit_o    = sel_word[idx[BITSEL_W-1:0]];
  end
endmodule

// File: rtl/rxf_first_pass.sv
module rxf_first_pass #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] pass_i,
  output logic [N-1:0] first_o,
  output logic         accept_o
);
  assign first_o[0] = pass_i[0];
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign first_o[i] = pass_i[i] & ~(|pass_i[i-1:0]);
  end
  assign accept_o = |first_o;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned N_EXACT    = 16,
  parameter int unsigned HASH_IDX_W = 12,
  localparam int unsigned WA_W      = HASH_IDX_W - BITSEL_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WA_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              ucast_promisc_i,
  input  logic              mcast_promisc_i,
  input  logic              bcast_en_i,
  input  logic [1:0]        mc_offset_i,
  input  logic              chk_start_i,
  input  logic [MAC_W-1:0]  dst_addr_i,
  output logic              dec_valid_o,
  output logic              accept_o
);
  logic             exact_hit, hash_hit, accept_d;
  logic [CHK_N-1:0] pass_v, first_sel;

  rxf_exact_table #(.N_ENT(N_EXACT), .AW(WA_W)) u_exact (
    .clk_i, .rst_ni,
    .we_i(wr_en_i), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
    .dst_i(dst_addr_i), .hit_o(exact_hit)
  );

  rxf_hash_table #(.IDX_W(HASH_IDX_W), .AW(WA_W)) u_hash (
    .clk_i, .rst_ni,
    .we_i(wr_en_i), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
    .key_i(dst_addr_i[47:32]), .mo_i(mc_offset_i), .hit_o(hash_hit)
  );

  always_comb begin
    pass_v            = '0;
    pass_v[CHK_UPE]   = ucast_promisc_i;
    pass_v[CHK_MPE]   = mcast_promisc_i & dst_addr_i[0];
    pass_v[CHK_BCAST] = bcast_en_i & (&dst_addr_i);
    pass_v[CHK_EXACT] = exact_hit;
    pass_v[CHK_HASH]  = hash_hit;
  end

  rxf_first_pass #(.N(CHK_N)) u_prio (
    .pass_i(pass_v), .first_o(first_sel), .accept_o(accept_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      accept_o    <= 1'b0;
    end else begin
      dec_valid_o <= chk_start_i;
      if (chk_start_i) accept_o <= accept_d;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        chk_start_i,
  input logic        ucast_promisc_i,
  input logic        mcast_promisc_i,
  input logic        bcast_en_i,
  input logic [47:0] dst_addr_i,
  input logic        exact_hit_i,
  input logic        hash_hit_i,
  input logic [4:0]  first_sel_i,
  input logic        dec_valid_o,
  input logic        accept_o
);
  p_valid_after_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_start_i |=> dec_valid_o);
  p_valid_only_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_start_i |=> !dec_valid_o);
  p_accept_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_start_i |=> $stable(accept_o));
  p_upe_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_start_i && ucast_promisc_i) |=> accept_o);
  p_mpe_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_start_i && mcast_promisc_i && dst_addr_i[0]) |=> accept_o);
  p_bcast_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_start_i && bcast_en_i && (&dst_addr_i)) |=> accept_o);
  p_exact_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_start_i && exact_hit_i) |=> accept_o);
  p_hash_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_start_i && hash_hit_i) |=> accept_o);
  p_drop_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_start_i && !ucast_promisc_i && !(mcast_promisc_i && dst_addr_i[0]) &&
     !(bcast_en_i && (&dst_addr_i)) && !exact_hit_i && !hash_hit_i) |=> !accept_o);
  p_one_decider_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(first_sel_i));
endmodule

bind rx_addr_filter rxf_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chk_start_i(chk_start_i),
  .ucast_promisc_i(ucast_promisc_i), .mcast_promisc_i(mcast_promisc_i),
  .bcast_en_i(bcast_en_i), .dst_addr_i(dst_addr_i),
  .exact_hit_i(exact_hit), .hash_hit_i(hash_hit), .first_sel_i(first_sel),
  .dec_valid_o(dec_valid_o), .accept_o(accept_o)
);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        upe, mpe, bam;
  logic [1:0]  mo;
  logic        start;
  logic [47:0] dst;
  logic        dec_valid, accept;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] sh_lo   [16];
  logic [31:0] sh_hi   [16];
  logic [31:0] sh_hash [128];

  always #4 clk = ~clk;

  rx_addr_filter u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ucast_promisc_i(upe), .mcast_promisc_i(mpe),
    .bcast_en_i(bam), .mc_offset_i(mo), .chk_start_i(start),
    .dst_addr_i(dst), .dec_valid_o(dec_valid), .accept_o(accept)
  );

  function automatic int shift_of(input logic [1:0] m);
    return (m == 2'd0) ? 4 : (m == 2'd1) ? 3 : (m == 2'd2) ? 2 : 0;
  endfunction

  function automatic int hidx(input logic [47:0] d, input logic [1:0] m);
    return (int'(d[47:32]) >> shift_of(m)) % 4096;
  endfunction

  function automatic bit model(input logic [47:0] d);
    int i;
    if (upe) return 1'b1;
    if (mpe && d[0]) return 1'b1;
    if (bam && d == 48'hFFFF_FFFF_FFFF) return 1'b1;
    for (int e = 0; e < 16; e++)
      if (sh_hi[e][31] && sh_lo[e] == d[31:0] && sh_hi[e][15:0] == d[47:32]) return 1'b1;
    i = hidx(d, mo);
    return sh_hash[i / 32][i % 32];
  endfunction

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = v;
    if (a < 32) begin
      if (a % 2 == 1) sh_hi[a / 2] = v; else sh_lo[a / 2] = v;
    end else if (a >= 128) sh_hash[a - 128] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frame(input logic [47:0] d, input string tag);
    bit exp;
    exp = model(d);
    @(negedge clk);
    start = 1'b1; dst = d;
    @(negedge clk);
    start = 1'b0;
    n_chk++;
    if (dec_valid !== 1'b1 || accept !== exp) begin
      n_fail++;
      $display("FAIL %s dst=%h valid=%b accept=%b expected valid=1 accept=%b",
               tag, d, dec_valid, accept, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit was_acc;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    upe = 1'b0; mpe = 1'b0; bam = 1'b0; mo = 2'd0; start = 1'b0; dst = '0;
    for (int e = 0; e < 16; e++) begin sh_lo[e] = '0; sh_hi[e] = '0; end
    for (int w = 0; w < 128; w++) sh_hash[w] = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (dec_valid !== 1'b0 || accept !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs valid=%b accept=%b expected 0 0", dec_valid, accept);
    end
    rst_n = 1'b1;
    @(negedge clk);
    frame(48'h0000_0000_0000, "R1");
    frame(48'h1234_5678_9ABC, "R1");
    frame(48'hFFFF_FFFF_FFFF, "R4 off");

    // R8: valid is a single pulse, accept holds
    upe = 1'b1;
    frame(48'h0000_0000_0002, "R8");
    upe = 1'b0;
    @(negedge clk);
    n_chk++;
    if (dec_valid !== 1'b0 || accept !== 1'b1) begin
      n_fail++;
      $display("FAIL R8 after pulse valid=%b accept=%b expected 0 1", dec_valid, accept);
    end

    // R2
    upe = 1'b1;
    for (int k = 0; k < 8; k++) frame(48'(k) * 48'h0123_4567_89AB, "R2");
    upe = 1'b0;

    // R3
    mpe = 1'b1;
    for (int b = 0; b < 16; b++) frame({40'h00_1122_3344, 8'(b)}, "R3");
    mpe = 1'b0;

    // R4
    bam = 1'b1;
    frame(48'hFFFF_FFFF_FFFF, "R4");
    frame(48'hFFFF_FFFF_FFFE, "R4");
    frame(48'h7FFF_FFFF_FFFF, "R4");
    bam = 1'b0;

    // R6/R7: exhaustive hash sweep with shift 0, cross-checked at shift 4
    for (int i = 0; i < 4096; i++) begin
      logic [47:0] d;
      d = {16'(i), 32'h0000_0002};
      wr(128 + i / 32, 32'h1 << (i % 32));
      mo = 2'd3;
      frame(d, "R7 sweep");
      frame(d ^ 48'h0001_0000_0000, "R7 neighbour");
      mo = 2'd0;
      frame(d, "R6 shift4");
      wr(128 + i / 32, 32'h0);
    end

    // R6: other offsets
    for (int m = 0; m < 3; m++) begin
      mo = 2'(m);
      for (int k = 0; k < 64; k++) begin
        logic [47:0] d;
        int ix;
        d  = {16'((k * 1031 + 7) % 65536), 32'h0000_0004};
        ix = hidx(d, mo);
        wr(128 + ix / 32, 32'h1 << (ix % 32));
        frame(d, "R6 offset");
        frame(d ^ {16'(1 << shift_of(mo)), 32'h0}, "R6 offset miss");
        wr(128 + ix / 32, 32'h0);
      end
    end
    mo = 2'd0;

    // R9: gap region writes ignored
    for (int a = 32; a < 128; a++) wr(a, 32'hFFFF_FFFF);
    for (int k = 0; k < 16; k++) frame({16'(k * 4099), 32'h0000_0010}, "R9");

    // R5: program all exact entries
    for (int e = 0; e < 16; e++) begin
      wr(2 * e,     {8'h5C, 8'(3 * e), 8'hA0, 8'(8'h10 + e)});
      wr(2 * e + 1, {1'b1, 15'h0, 8'h70, 8'(8'h33 ^ e)});
    end
    for (int e = 0; e < 16; e++)
      frame({8'h70, 8'(8'h33 ^ e), 8'h5C, 8'(3 * e), 8'hA0, 8'(8'h10 + e)}, "R5 hit");
    for (int b = 0; b < 48; b++)
      frame({8'h70, 8'h33, 8'h5C, 8'h00, 8'hA0, 8'h10} ^ (48'h1 << b), "R5 flip");
    wr(11, {1'b0, 15'h0, 8'h70, 8'(8'h33 ^ 5)});
    frame({8'h70, 8'(8'h33 ^ 5), 8'h5C, 8'(15), 8'hA0, 8'h15}, "R5 invalid");

    // R10: every combination of controls on hit/miss addresses
    for (int c = 0; c < 8; c++) begin
      upe = c[0]; mpe = c[1]; bam = c[2];
      frame({8'h70, 8'h33, 8'h5C, 8'h00, 8'hA0, 8'h10}, "R10 exact");
      frame(48'hFFFF_FFFF_FFFF, "R10 bcast");
      frame(48'h0000_0000_0001, "R10 group");
      frame(48'h0000_0000_0002, "R10 none");
    end
    upe = 1'b0; mpe = 1'b0; bam = 1'b0;
    frame(48'h0000_0000_0002, "R10 none");
    was_acc = accept;
    @(negedge clk);
    n_chk++;
    if (accept !== was_acc) begin
      n_fail++;
      $display("FAIL R8 accept changed without start: %b expected %b", accept, was_acc);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule